// File: doc/BRIEF.md
# Pressure-Driven Hardware Thread Switcher

This block chooses which of several resident hardware thread contexts owns an in-order issue pipeline. Each context's thread and control state stays in dedicated on-chip context storage. A switch therefore moves no data through memory and takes effect on the next clock edge.

The running thread pays for every instruction it decodes. The decode stage reports an opcode class with a valid strobe. A programmable table turns that class into a cost, and the cost is added to the running context's pressure counter. Once that counter, including the current instruction's cost, reaches a programmable threshold, the thread must yield. The next ready context in round-robin order then takes over, and a one-cycle switch pulse marks the change.

Switching is driven only by weighted instruction cost. It does not depend on a time slice or on stall events. A configuration port sets the threshold and writes single cost-table entries.

Top module: `pys_top`

## Requirements
- R1: While rstN is low and in the first cycle after it is released, activeCtx is 0 and switchPulse is 0. Reset clears every pressure counter, sets every cost-table entry to 1 and sets the threshold to 16.
- R2: A cycle with cfgCostWe high writes cfgCost into table entry cfgCostIdx. Charges take the new cost from the next cycle onward, and a decode in the same cycle as the write is charged the old cost.
- R3: A cycle with cfgThreshWe high loads cfgThresh as the threshold, and the compare uses it from the next cycle onward. With a threshold of 0, the block yields every cycle even when no instruction is decoded.
- R4: Each cycle with decValid high adds the table cost of decClass (a 3-bit class) to the running context's pressure. A cycle with decValid low adds nothing.
- R5: The block yields when the running context's pressure plus the current cycle's charge is greater than or equal to the threshold. In that case activeCtx takes the new index at the next clock edge. switchPulse is high for exactly that one following cycle.
- R6: The 16-bit pressure sum saturates at 0xFFFF instead of wrapping, so an overflowing charge still causes a yield at a threshold of 0xFFFF.
- R7: On a yield, the next context is the first one whose bit in ctxReady is high, searching upward from activeCtx+1 and wrapping past 7 to 0. Contexts whose ready bit is low are skipped.
- R8: If no other context is ready when a yield is due, activeCtx is unchanged and switchPulse stays low. The running context's pressure is still cleared to zero.
- R9: On a yield, the cost of the instruction decoded in that same cycle counts toward the yield decision. The outgoing context's pressure is then cleared to zero.
- R10: Only the running context is charged. A context that gains the pipeline starts from zero pressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| decValid | input | 1 | An instruction of the running thread is decoded this cycle |
| decClass | input | 3 | Opcode class of the decoded instruction |
| ctxReady | input | 8 | Per-context ready flags |
| cfgThreshWe | input | 1 | Threshold write strobe |
| cfgThresh | input | 16 | New threshold value |
| cfgCostWe | input | 1 | Cost-table write strobe |
| cfgCostIdx | input | 3 | Class whose cost is written |
| cfgCost | input | 8 | New cost value |
| activeCtx | output | 3 | Index of the context that owns the pipeline |
| switchPulse | output | 1 | High for one cycle after the active context changes |

## Verification
The pressure counters are hidden, so a corrupted counter, cost entry or threshold appears at the ports as a yield that comes too early or too late. That error becomes visible in the first cycle after the decode that should, or should not, have crossed the threshold. A wrong round-robin search or a missed clear shows up as a wrong activeCtx value, or a misplaced switchPulse, in the cycle right after the yield. The stimulus therefore places exact-threshold crossings, saturating sums and sparse ready masks so that each fault changes a pulse or an index at a known cycle.

// File: rtl/pys_pkg.sv
package pys_pkg;
  parameter int NUM_CTX = 8;
  parameter int CLASS_W = 3;
  parameter int COST_W  = 8;
  parameter int PRES_W  = 16;
  localparam int CTX_W     = $clog2(NUM_CTX);
  localparam int NUM_CLASS = 1 << CLASS_W;

  // strobes from control to datapath
  typedef struct packed {
    logic             clearPres;
    logic [CTX_W-1:0] selCtx;
  } ctlStrobe_t;
endpackage

// File: rtl/pys_datapath.sv
module pys_datapath
  import pys_pkg::*;
#(
  parameter int RST_THRESH = 16,
  parameter int RST_COST   = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               decValid,
  input  logic [CLASS_W-1:0] decClass,
  input  logic               cfgThreshWe,
  input  logic [PRES_W-1:0]  cfgThresh,
  input  logic               cfgCostWe,
  input  logic [CLASS_W-1:0] cfgCostIdx,
  input  logic [COST_W-1:0]  cfgCost,
  input  ctlStrobe_t         ctl,
  output logic               trigger
);
  localparam int SUM_W = PRES_W + 1;

  logic [COST_W-1:0] costTab [NUM_CLASS];
  logic [PRES_W-1:0] presQ   [NUM_CTX];
  logic [PRES_W-1:0] threshQ;
  logic [SUM_W-1:0]  sumWide;
  logic [PRES_W-1:0] sumSat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) threshQ <= PRES_W'(RST_THRESH);
    else if (cfgThreshWe) threshQ <= cfgThresh;
  end

  for (genvar c = 0; c < NUM_CLASS; c++) begin : g_cost
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) costTab[c] <= COST_W'(RST_COST);
      else if (cfgCostWe && (cfgCostIdx == CLASS_W'(c))) costTab[c] <= cfgCost;
    end
  end

  always_comb begin
    sumWide = {1'b0, presQ[ctl.selCtx]};
    if (decValid) sumWide = sumWide + SUM_W'(costTab[decClass]);
    sumSat  = sumWide[PRES_W] ? '1 : sumWide[PRES_W-1:0];
    trigger = (sumSat >= threshQ);
  end

  for (genvar i = 0; i < NUM_CTX; i++) begin : g_pres
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) presQ[i] <= '0;
      else if (ctl.selCtx == CTX_W'(i)) presQ[i] <= ctl.clearPres ? '0 : sumSat;
    end
  end
endmodule

// File: rtl/pys_control.sv
module pys_control
  import pys_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               trigger,
  input  logic [NUM_CTX-1:0] ctxReady,
  output ctlStrobe_t         ctl,
  output logic [CTX_W-1:0]   activeCtx,
  output logic               switchPulse
);
  logic [CTX_W-1:0] curQ;
  logic [CTX_W-1:0] nextCtx;
  logic             found;
  logic             pulseQ;

  always_comb begin
    found   = 1'b0;
    nextCtx = curQ;
    for (int k = 1; k < NUM_CTX; k++) begin
      if (!found && ctxReady[curQ + CTX_W'(k)]) begin
        found   = 1'b1;
        nextCtx = curQ + CTX_W'(k);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curQ   <= '0;
      pulseQ <= 1'b0;
    end else begin
      pulseQ <= trigger && found;
      if (trigger && found) curQ <= nextCtx;
    end
  end

  assign ctl.selCtx    = curQ;
  assign ctl.clearPres = trigger;
  assign activeCtx     = curQ;
  assign switchPulse   = pulseQ;
endmodule

// File: rtl/pys_top.sv
module pys_top
  import pys_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               decValid,
  input  logic [CLASS_W-1:0] decClass,
  input  logic [NUM_CTX-1:0] ctxReady,
  input  logic               cfgThreshWe,
  input  logic [PRES_W-1:0]  cfgThresh,
  input  logic               cfgCostWe,
  input  logic [CLASS_W-1:0] cfgCostIdx,
  input  logic [COST_W-1:0]  cfgCost,
  output logic [CTX_W-1:0]   activeCtx,
  output logic               switchPulse
);
  ctlStrobe_t ctl;
  logic       trigger;

  pys_datapath u_dp (
    .clk(clk), .rstN(rstN), .decValid(decValid), .decClass(decClass),
    .cfgThreshWe(cfgThreshWe), .cfgThresh(cfgThresh),
    .cfgCostWe(cfgCostWe), .cfgCostIdx(cfgCostIdx), .cfgCost(cfgCost),
    .ctl(ctl), .trigger(trigger)
  );

  pys_control u_ctl (
    .clk(clk), .rstN(rstN), .trigger(trigger), .ctxReady(ctxReady),
    .ctl(ctl), .activeCtx(activeCtx), .switchPulse(switchPulse)
  );
endmodule

// File: rtl/pys_checker.sv
module pys_checker
  import pys_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic [NUM_CTX-1:0] ctxReady,
  input logic [CTX_W-1:0]   activeCtx,
  input logic               switchPulse
);
  logic [CTX_W-1:0]   prevCtx;
  logic [NUM_CTX-1:0] prevReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevCtx   <= '0;
      prevReady <= '0;
    end else begin
      prevCtx   <= activeCtx;
      prevReady <= ctxReady;
    end
  end

  function automatic logic skippedReady(input logic [CTX_W-1:0] fromCtx,
                                        input logic [CTX_W-1:0] toCtx,
                                        input logic [NUM_CTX-1:0] rdy);
    logic hit;
    logic done;
    hit  = 1'b0;
    done = 1'b0;
    for (int k = 1; k < NUM_CTX; k++) begin
      if (!done) begin
        if (fromCtx + CTX_W'(k) == toCtx) done = 1'b1;
        else if (rdy[fromCtx + CTX_W'(k)]) hit = 1'b1;
      end
    end
    return hit;
  endfunction

  p_reset_ctx_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (activeCtx == '0 && !switchPulse));

  p_pulse_moves_r5: assert property (@(posedge clk) disable iff (!rstN)
    switchPulse |-> (activeCtx != prevCtx));

  p_hold_no_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    !switchPulse |-> (activeCtx == prevCtx));

  p_target_ready_r7: assert property (@(posedge clk) disable iff (!rstN)
    switchPulse |-> prevReady[activeCtx]);

  p_no_skip_r7: assert property (@(posedge clk) disable iff (!rstN)
    switchPulse |-> !skippedReady(prevCtx, activeCtx, prevReady));
endmodule

bind pys_top pys_checker u_chk (
  .clk(clk), .rstN(rstN), .ctxReady(ctxReady),
  .activeCtx(activeCtx), .switchPulse(switchPulse)
);

// File: tb/tb_pys_top.sv
module tb_pys_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       decValid = 1'b0;
  logic [2:0] decClass = '0;
  logic [7:0] ctxReady = 8'hFF;
  logic       cfgThreshWe = 1'b0;
  logic [15:0] cfgThresh = '0;
  logic       cfgCostWe = 1'b0;
  logic [2:0] cfgCostIdx = '0;
  logic [7:0] cfgCost = '0;
  logic [2:0] activeCtx;
  logic       switchPulse;

  int checks = 0;
  int failures = 0;

  pys_top dut (
    .clk(clk), .rstN(rstN), .decValid(decValid), .decClass(decClass),
    .ctxReady(ctxReady), .cfgThreshWe(cfgThreshWe), .cfgThresh(cfgThresh),
    .cfgCostWe(cfgCostWe), .cfgCostIdx(cfgCostIdx), .cfgCost(cfgCost),
    .activeCtx(activeCtx), .switchPulse(switchPulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {decValid, class, ready, expCtx, expPulse}; threshold 4, class3 costs 3, class7 costs 4
  localparam logic [15:0] VEC [NVEC] = '{
    {1'b1, 3'd0, 8'hFF, 3'd0, 1'b0},
    {1'b1, 3'd3, 8'hFF, 3'd1, 1'b1},
    {1'b0, 3'd0, 8'hFF, 3'd1, 1'b0},
    {1'b1, 3'd7, 8'hFF, 3'd2, 1'b1},
    {1'b1, 3'd3, 8'h04, 3'd2, 1'b0},
    {1'b1, 3'd0, 8'h04, 3'd2, 1'b0},
    {1'b1, 3'd3, 8'h84, 3'd2, 1'b0},
    {1'b1, 3'd0, 8'h84, 3'd7, 1'b1},
    {1'b1, 3'd7, 8'h03, 3'd0, 1'b1},
    {1'b1, 3'd7, 8'h03, 3'd1, 1'b1},
    {1'b0, 3'd7, 8'hFF, 3'd1, 1'b0},
    {1'b1, 3'd1, 8'hFF, 3'd1, 1'b0}
  };

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [2:0] cls, input logic [7:0] rdy);
    decValid = v;
    decClass = cls;
    ctxReady = rdy;
    @(posedge clk);
    @(negedge clk);
    cfgThreshWe = 1'b0;
    cfgCostWe   = 1'b0;
    decValid    = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    decValid = 1'b0;
    ctxReady = 8'hFF;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic setThresh(input logic [15:0] t);
    cfgThreshWe = 1'b1;
    cfgThresh   = t;
    step(1'b0, 3'd0, 8'hFF);
  endtask

  task automatic setCost(input logic [2:0] idx, input logic [7:0] c);
    cfgCostWe  = 1'b1;
    cfgCostIdx = idx;
    cfgCost    = c;
    step(1'b0, 3'd0, 8'hFF);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic anyPulse;
    rstN = 1'b0;
    @(negedge clk);
    check(activeCtx == 3'd0 && !switchPulse, "R1 in reset", activeCtx, 0);
    doReset();
    @(negedge clk);
    check(activeCtx == 3'd0 && !switchPulse, "R1 after reset", activeCtx, 0);

    // R1/R4: default threshold 16, cost 1
    anyPulse = 1'b0;
    for (int i = 0; i < 15; i++) begin
      step(1'b1, 3'd4, 8'hFF);
      anyPulse |= switchPulse;
    end
    check(!anyPulse && activeCtx == 3'd0, "R1 R4 default no yield before 16", activeCtx, 0);
    step(1'b1, 3'd4, 8'hFF);
    check(switchPulse && activeCtx == 3'd1, "R1 R4 R5 default yield at 16", activeCtx, 1);

    // vector table
    doReset();
    setThresh(16'd4);
    setCost(3'd3, 8'd3);
    setCost(3'd7, 8'd4);
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][15], VEC[i][14:12], VEC[i][11:4]);
      // R5 R7 R8 R9 R10
      check(activeCtx == VEC[i][3:1], $sformatf("R7 vec%0d ctx", i), activeCtx, VEC[i][3:1]);
      check(switchPulse == VEC[i][0], $sformatf("R5 vec%0d pulse", i), switchPulse, VEC[i][0]);
    end

    // R3: threshold 0 yields every cycle
    doReset();
    setThresh(16'd0);
    step(1'b0, 3'd0, 8'hFF);
    check(switchPulse && activeCtx == 3'd1, "R3 thresh0 first", activeCtx, 1);
    step(1'b0, 3'd0, 8'hFF);
    check(switchPulse && activeCtx == 3'd2, "R3 thresh0 second", activeCtx, 2);

    // R2: cost write with same-cycle decode uses old cost
    doReset();
    setThresh(16'd9);
    cfgCostWe = 1'b1; cfgCostIdx = 3'd5; cfgCost = 8'd9;
    step(1'b1, 3'd5, 8'hFF);
    check(!switchPulse && activeCtx == 3'd0, "R2 old cost on write cycle", switchPulse, 0);
    step(1'b1, 3'd5, 8'hFF);
    check(switchPulse && activeCtx == 3'd1, "R2 new cost next cycle", switchPulse, 1);

    // R6: saturation
    doReset();
    setThresh(16'hFFFF);
    setCost(3'd0, 8'd255);
    setCost(3'd2, 8'd200);
    anyPulse = 1'b0;
    for (int i = 0; i < 256; i++) begin
      step(1'b1, 3'd0, 8'hFF);
      anyPulse |= switchPulse;
    end
    step(1'b1, 3'd2, 8'hFF);
    anyPulse |= switchPulse;
    check(!anyPulse && activeCtx == 3'd0, "R6 below saturation", activeCtx, 0);
    step(1'b1, 3'd0, 8'hFF);
    check(switchPulse && activeCtx == 3'd1, "R6 saturated sum yields", activeCtx, 1);
    step(1'b0, 3'd0, 8'hFF);
    check(!switchPulse, "R5 pulse one cycle", switchPulse, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule